// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing slave logic for a 512-byte non-volatile memory. It oversamples the two-wire clock and data lines on a fast system clock, passes both through a short synchroniser, and from the synchronised samples detects START and STOP conditions and clock edges. It receives a control byte and compares it with a fixed device code and two strap inputs. It then keeps a 9-bit address pointer and either hands incoming data bytes to an external page buffer or fetches bytes from the array read port and shifts them out.

The data line is open-drain. The engine does not drive a level onto it. It raises an output enable that pulls the line low, and the line reads high whenever nothing pulls it. After a write, the external program sequencer raises a busy input. While busy is high the engine stays silent on control bytes, so a master can poll until it is acknowledged again. The array read port is asynchronous: the array must present the byte at `rd_addr_o` on `rd_data_i`.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: A falling data line while the clock is high (START) begins a new control-byte phase. A rising data line while the clock is high (STOP) returns the engine to idle with the pull-down released.
- R2: The control byte is received MSB first. Its bits [7:4] must equal 1010 and its bits [3:2] must equal `chip_sel_i[1:0]`. Bit 1 is the block select and bit 0 is the direction (1 = read). On a match the engine pulls the line low for the whole ninth clock. On a mismatch it gives no acknowledge and ignores every further clock until the next START.
- R3: While `busy_i` is high, a control byte is never acknowledged, whatever its direction.
- R4: In a write, the byte after the control byte loads pointer bits [7:0] and the block-select bit loads pointer bit 8. Each following data byte is acknowledged. Each one is also presented for one cycle on `pb_we_o`, together with the pointer value at that moment and the byte, after which the pointer increments.
- R5: `prog_go_o` pulses for one cycle after a STOP if at least one data byte was handed to the page buffer since the previous STOP. A write that carries only a word address starts no program cycle.
- R6: In a read, the engine sends the byte at the pointer MSB first, changing the data line only after a clock falling edge, and increments the pointer as it loads each byte. It sends the next byte while the master acknowledges, and releases the line after the master's non-acknowledge.
- R7: A read issued without a preceding word address starts at the current pointer, and the block-select bit of a read control byte leaves the pointer unchanged.
- R8: A pointer increment wraps from the last location of a 256-byte block to the first location of the same block: 0x0FF goes to 0x000 and 0x1FF goes to 0x100.
- R9: A repeated START at any point abandons the byte in progress without handing it on, and returns the engine to the control-byte phase.
- R10: The pull-down enable changes only while the synchronised clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND level) |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| chip_sel_i | input | 2 | Strap levels compared with control-byte bits [3:2] |
| busy_i | input | 1 | Program cycle in progress; suppresses the control-byte acknowledge |
| rd_addr_o | output | 9 | Address pointer, also the array read address |
| rd_data_i | input | 8 | Array byte at rd_addr_o |
| pb_we_o | output | 1 | One-cycle strobe: a data byte for the page buffer |
| pb_addr_o | output | 9 | Target address of the strobed byte |
| pb_data_o | output | 8 | Strobed data byte |
| prog_go_o | output | 1 | One-cycle pulse after STOP: start the program cycle |

## Verification
Two functions can land in the same cycle. The first is the acknowledge of a data byte; the second is a pointer increment that crosses a block end. They meet when the byte hand-off and the wrap happen on one falling edge. A page write is started at 0x1FE and three bytes are sent. The scoreboard expects the hand-off addresses 0x1FE, 0x1FF and 0x100 with every byte acknowledged, then one program pulse at STOP. The same coincidence on the read side comes from loading a byte at 0x0FF. There, the second byte returned must come from 0x000 and not from 0x100.

// File: rtl/eei2c_pkg.sv
package eei2c_pkg;

  localparam int BYTE_W = 8;
  localparam int PTR_W  = BYTE_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    S_IDLE,
    S_CTRL,
    S_WADR,
    S_WDAT,
    S_ACK,
    S_RDAT,
    S_RACK
  } eng_st_t;

  // next pointer: low byte counts, block bit held
  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return {p[PTR_W-1], p[BYTE_W-1:0] + 1'b1};
  endfunction

  // control byte selects this device
  function automatic logic ctrl_hit(input logic [BYTE_W-1:0] b,
                                    input logic [1:0] cs,
                                    input logic [3:0] code);
    return (b[7:4] == code) && (b[3:2] == cs);
  endfunction

endpackage

// File: rtl/eei2c_line_mon.sv
module eei2c_line_mon #(
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  localparam int DEPTH = (SYNC_DEPTH < 2) ? 2 : SYNC_DEPTH;

  logic [DEPTH-1:0] scl_q, sda_q;
  logic             scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[DEPTH-2:0], scl_i};
      sda_q <= {sda_q[DEPTH-2:0], sda_i};
      scl_d <= scl_q[DEPTH-1];
      sda_d <= sda_q[DEPTH-1];
    end
  end

  assign scl_s     = scl_q[DEPTH-1];
  assign sda_s     = sda_q[DEPTH-1];
  assign scl_rise  =  scl_s & ~scl_d;
  assign scl_fall  = ~scl_s &  scl_d;
  assign start_evt =  scl_s & scl_d &  sda_d & ~sda_s;
  assign stop_evt  =  scl_s & scl_d & ~sda_d &  sda_s;

endmodule

// File: rtl/eei2c_ptr.sv
module eei2c_ptr import eei2c_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  input  logic             inc,
  output logic [PTR_W-1:0] ptr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_val;
    else if (inc)  ptr <= ptr_next(ptr);
  end

  AST_PTR_BLOCK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load) |=> (ptr[PTR_W-1] == $past(ptr[PTR_W-1]))) else $error("block bit moved"); // R8

endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave import eei2c_pkg::*; #(
  parameter int          SYNC_DEPTH = 2,
  parameter logic [3:0]  DEV_CODE   = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [1:0]        chip_sel_i,
  input  logic              busy_i,
  output logic [PTR_W-1:0]  rd_addr_o,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              pb_we_o,
  output logic [PTR_W-1:0]  pb_addr_o,
  output logic [BYTE_W-1:0] pb_data_o,
  output logic              prog_go_o
);

  // bus events from the line monitor
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  eei2c_line_mon #(.SYNC_DEPTH(SYNC_DEPTH)) u_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  eng_st_t            state, ret_st;
  logic [BYTE_W-1:0]  shreg;
  logic [CNT_W-1:0]   bitcnt;
  logic               blk, mack, wr_pend;
  logic [PTR_W-1:0]   ptr;

  // named internal events
  logic byte_end, load_rd, ptr_load, ptr_inc;
  assign byte_end = scl_fall && (bitcnt == CNT_W'(BYTE_W));
  assign load_rd  = scl_fall && (((state == S_ACK) && (ret_st == S_RDAT)) ||
                                 ((state == S_RACK) && mack));
  assign ptr_load = (state == S_WADR) && byte_end;
  assign ptr_inc  = ((state == S_WDAT) && byte_end) || load_rd;

  eei2c_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val({blk, shreg}),
    .inc(ptr_inc), .ptr(ptr)
  );

  assign rd_addr_o = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      ret_st    <= S_IDLE;
      shreg     <= '0;
      bitcnt    <= '0;
      blk       <= 1'b0;
      mack      <= 1'b0;
      wr_pend   <= 1'b0;
      sda_oe_o  <= 1'b0;
      pb_we_o   <= 1'b0;
      pb_addr_o <= '0;
      pb_data_o <= '0;
      prog_go_o <= 1'b0;
    end else begin
      pb_we_o   <= 1'b0;
      prog_go_o <= 1'b0;
      if (stop_evt) begin
        state     <= S_IDLE;
        sda_oe_o  <= 1'b0;
        prog_go_o <= wr_pend;
        wr_pend   <= 1'b0;
      end else if (start_evt) begin
        state    <= S_CTRL;
        bitcnt   <= '0;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state)
          S_CTRL, S_WADR, S_WDAT: begin
            if (scl_rise && (bitcnt < CNT_W'(BYTE_W))) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end
            if (byte_end) begin
              if (state == S_CTRL) begin
                if (ctrl_hit(shreg, chip_sel_i, DEV_CODE) && !busy_i) begin
                  sda_oe_o <= 1'b1;
                  blk      <= shreg[1];
                  ret_st   <= shreg[0] ? S_RDAT : S_WADR;
                  state    <= S_ACK;
                end else begin
                  state <= S_IDLE;
                end
              end else begin
                sda_oe_o <= 1'b1;
                ret_st   <= S_WDAT;
                state    <= S_ACK;
                if (state == S_WDAT) begin
                  pb_we_o   <= 1'b1;
                  pb_addr_o <= ptr;
                  pb_data_o <= shreg;
                  wr_pend   <= 1'b1;
                end
              end
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (ret_st == S_RDAT) begin
                shreg    <= rd_data_i;
                sda_oe_o <= ~rd_data_i[BYTE_W-1];
              end else begin
                sda_oe_o <= 1'b0;
              end
              state <= ret_st;
            end
          end
          S_RDAT: begin
            if (scl_rise) bitcnt <= bitcnt + 1'b1;
            if (scl_fall) begin
              if (bitcnt == CNT_W'(BYTE_W)) begin
                sda_oe_o <= 1'b0;
                mack     <= 1'b0;
                state    <= S_RACK;
              end else begin
                shreg    <= {shreg[BYTE_W-2:0], 1'b0};
                sda_oe_o <= ~shreg[BYTE_W-2];
              end
            end
          end
          S_RACK: begin
            if (scl_rise) mack <= ~sda_s;
            if (scl_fall) begin
              if (mack) begin
                bitcnt   <= '0;
                shreg    <= rd_data_i;
                sda_oe_o <= ~rd_data_i[BYTE_W-1];
                state    <= S_RDAT;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!sda_oe_o && state == S_IDLE)) else $error("stop"); // R1
  AST_START_TO_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (state == S_CTRL)) else $error("restart"); // R9
  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CTRL && byte_end && busy_i) |=> !sda_oe_o) else $error("busy ack"); // R3
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_s) else $error("oe edge"); // R10
  AST_PROG_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    prog_go_o |-> $past(stop_evt)) else $error("prog"); // R5
  AST_PB_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    pb_we_o |-> (pb_addr_o[PTR_W-1] == blk)) else $error("pb block"); // R4

endmodule

// File: tb/eeprom_i2c_slave_tb_top.sv
module eeprom_i2c_slave_tb_top;
  localparam int Q = 8;
  localparam logic [1:0] CS = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, busy = 1'b0;
  logic sda_oe, pb_we, prog_go;
  logic [8:0] rd_addr, pb_addr;
  logic [7:0] rd_data, pb_data;
  logic [7:0] mem [512];
  wire  sda_line = m_sda & ~sda_oe;

  int checks = 0, errors = 0, prog_cnt = 0;
  bit done = 0;
  logic [16:0] exp_q [$];

  always #5 clk = ~clk;

  eeprom_i2c_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .chip_sel_i(CS), .busy_i(busy), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .pb_we_o(pb_we), .pb_addr_o(pb_addr), .pb_data_o(pb_data), .prog_go_o(prog_go)
  );

  assign rd_data = mem[rd_addr];

  initial for (int i = 0; i < 512; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 3));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(2*Q); m_sda = 1'b0; wq(2*Q); m_scl = 1'b0; wq(Q);
  endtask
  task automatic bus_stop();
    m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(2*Q); m_sda = 1'b1; wq(2*Q);
  endtask
  task automatic send_bit(input logic b);
    m_sda = b; wq(Q); m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq(Q);
  endtask
  task automatic recv_bit(output logic b);
    m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); b = sda_line; wq(Q); m_scl = 1'b0; wq(Q);
  endtask
  task automatic wr_byte(input logic [7:0] v, output bit acked);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    acked = ~b;
  endtask
  task automatic rd_byte(output logic [7:0] v, input bit give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin recv_bit(b); v[i] = b; end
    send_bit(~give_ack);
  endtask
  function automatic logic [7:0] ctl(input logic bk, input logic rd);
    return {4'b1010, CS, bk, rd};
  endfunction

  // scoreboard monitor
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pb_we) begin
        if (exp_q.size() == 0) chk(1'b0, "R4 unexpected page push", int'({pb_addr, pb_data}), 0);
        else begin
          logic [16:0] e;
          e = exp_q.pop_front();
          chk({pb_addr, pb_data} == e, "R4 page push addr/data", int'({pb_addr, pb_data}), int'(e));
        end
      end
      if (prog_go) prog_cnt++;
      if (sda_oe != prev_oe) chk(m_scl == 1'b0, "R10 pull-down changed with clock high", int'(m_scl), 0);
      prev_oe = sda_oe;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    bit a;
    logic [7:0] d;
    wq(5); rst_n = 1'b1; wq(5);
    // reset state
    chk(sda_oe == 0, "R1 reset pull-down", int'(sda_oe), 0);
    chk(rd_addr == 0, "R7 reset pointer", int'(rd_addr), 0);
    chk(pb_we == 0 && prog_go == 0, "R5 reset strobes", int'({pb_we, prog_go}), 0);

    // R3: busy suppresses control-byte acknowledge
    busy = 1'b1;
    bus_start(); wr_byte(ctl(0, 0), a); chk(!a, "R3 busy write poll nack", a, 0); bus_stop();
    bus_start(); wr_byte(ctl(0, 1), a); chk(!a, "R3 busy read poll nack", a, 0); bus_stop();
    busy = 1'b0;

    // R2: mismatches ignored
    bus_start(); wr_byte({4'b1010, 2'b01, 2'b00}, a); chk(!a, "R2 chip-select mismatch nack", a, 0);
    wr_byte(8'h55, a); chk(!a, "R2 ignored after mismatch", a, 0); bus_stop();
    bus_start(); wr_byte({4'b1011, CS, 2'b00}, a); chk(!a, "R2 device code mismatch nack", a, 0); bus_stop();
    chk(prog_cnt == 0, "R5 no program after ignored traffic", prog_cnt, 0);

    // R4 R8 R5: page write across block end
    bus_start(); wr_byte(ctl(1, 0), a); chk(a, "R2 control ack", a, 1);
    wr_byte(8'hFE, a); chk(a, "R4 word address ack", a, 1);
    exp_q.push_back({9'h1FE, 8'hA1}); wr_byte(8'hA1, a); chk(a, "R4 data ack", a, 1);
    exp_q.push_back({9'h1FF, 8'h3C}); wr_byte(8'h3C, a); chk(a, "R4 data ack", a, 1);
    exp_q.push_back({9'h100, 8'h7E}); wr_byte(8'h7E, a); chk(a, "R8 data ack after wrap", a, 1);
    bus_stop(); wq(4);
    chk(prog_cnt == 1, "R5 one program pulse after page write", prog_cnt, 1);
    chk(rd_addr == 9'h101, "R8 pointer stays in upper block", int'(rd_addr), 'h101);

    // R9 R6: random read via repeated START
    bus_start(); wr_byte(ctl(0, 0), a); wr_byte(8'h10, a);
    bus_start(); wr_byte(ctl(0, 1), a); chk(a, "R9 read control ack after restart", a, 1);
    rd_byte(d, 1); chk(d == mem[9'h010], "R6 first read byte", d, mem[9'h010]);
    rd_byte(d, 0); chk(d == mem[9'h011], "R6 sequential read byte", d, mem[9'h011]);
    chk(sda_oe == 0, "R6 released after nack", int'(sda_oe), 0);
    bus_stop(); wq(4);
    chk(prog_cnt == 1, "R5 address-only write starts no program", prog_cnt, 1);
    chk(rd_addr == 9'h012, "R6 pointer incremented per byte", int'(rd_addr), 'h012);

    // R7: current-address read, block bit of read ignored
    bus_start(); wr_byte(ctl(1, 1), a); chk(a, "R7 current read ack", a, 1);
    rd_byte(d, 0); chk(d == mem[9'h012], "R7 current-address byte", d, mem[9'h012]);
    bus_stop();

    // R8: read wraps in lower block
    bus_start(); wr_byte(ctl(0, 0), a); wr_byte(8'hFF, a);
    bus_start(); wr_byte(ctl(0, 1), a);
    rd_byte(d, 1); chk(d == mem[9'h0FF], "R8 byte at block end", d, mem[9'h0FF]);
    rd_byte(d, 0); chk(d == mem[9'h000], "R8 wrapped byte", d, mem[9'h000]);
    bus_stop();

    // R9: restart in middle of data byte
    bus_start(); wr_byte(ctl(1, 0), a); wr_byte(8'h40, a);
    send_bit(1); send_bit(0); send_bit(1); send_bit(1);
    bus_start(); wr_byte(ctl(0, 1), a); chk(a, "R9 control ack after abort", a, 1);
    rd_byte(d, 0); chk(d == mem[9'h140], "R9 pointer from aborted write", d, mem[9'h140]);
    bus_stop(); wq(4);
    chk(prog_cnt == 1, "R9 aborted byte starts no program", prog_cnt, 1);
    chk(exp_q.size() == 0, "R4 all expected pushes seen", exp_q.size(), 0);

    finish_run();
  end
endmodule